// File: doc/BRIEF.md
# Symmetric Activation Lookup Unit

This block turns the accumulated sum of one neuron into a signed activation value. It uses a single host-loadable table that holds only the magnitude half of the transfer curve. The incoming sum is saturated to the range the table covers. Its fractional bits are dropped, and the remaining magnitude forms an 8-bit table address. The 8-bit entry read from the table is then folded back into a full curve according to the sign of the input.

Two fold rules are offered. The odd rule negates the entry for negative inputs, which suits tanh-like curves. The offset rule returns the full-scale value minus the entry for negative inputs, which suits sigmoid-like curves. A final ±1 coefficient can negate the whole result. So one unit can realise several activation shapes without any change to the hardware.

The unit is fully pipelined. It accepts one sum per clock, and each result appears exactly two cycles after its input. Fold mode and coefficient are sampled together with each sum, so they may change from one sample to the next.

Top module: `act_lut_unit`

## Requirements
- R1: Writing `tbl_data` to address `tbl_addr` with `tbl_we` high replaces that entry. A sum presented in the same cycle as the write, or in any later cycle, sees the new entry. A sum presented one cycle before the write sees the old entry.
- R2: A sum whose magnitude is at least 256·2^FRAC_W (default 65536) uses table address 255. This holds for both signs, including the most negative representable sum.
- R3: Below saturation, the table address is floor(|sum| / 2^FRAC_W). For a negative sum this truncates the magnitude toward zero, so -0x1FF and 0x1FF both use address 1.
- R4: With `sym_mode`=0 (odd fold) and `coef_neg`=0, a sum ≥ 0 gives +T and a negative sum gives -T, where T is the addressed entry.
- R5: With `sym_mode`=1 (offset fold) and `coef_neg`=0, a sum ≥ 0 gives +T and a negative sum gives 255-T.
- R6: With `coef_neg`=1 the folded value is negated. Every result lies in -255..+255.
- R7: `out_valid` is `in_valid` delayed by exactly two cycles, with one result per clock on back-to-back input. `out_value` is 0 whenever `out_valid` is low.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_value` is 0.
- R9: A sum of exactly zero is treated as non-negative and returns +T at address 0 in both fold modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| in_valid | input | 1 | Sum sample valid |
| in_sum | input | SUM_W (24) | Signed accumulated sum, FRAC_W (8) fractional bits |
| sym_mode | input | 1 | Fold rule: 0 odd, 1 offset |
| coef_neg | input | 1 | Coefficient: 0 means +1, 1 means -1 |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W (8) | Table write address |
| tbl_data | input | DATA_W (8) | Table write data |
| out_valid | output | 1 | Result valid |
| out_value | output | DATA_W+1 (9) | Signed activation result |

## Verification
A wrong address or saturation decision shows up two cycles after the offending sum, as a result equal to a neighbouring table entry. The bench fills the table with distinct values so that such a mix-up cannot hide. A wrong fold or coefficient flag flips the sign or the offset of that same result. A misaligned pipeline stage shows on the very next output cycle, either as a valid strobe out of place or as a result that belongs to the adjacent sample. Table-write ordering faults appear only when a write and a lookup collide on one address, so those collisions are forced in both orders.

// File: rtl/act_lut_unit.sv
module act_lut_unit #(
  parameter int SUM_W  = 24,
  parameter int FRAC_W = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SUM_W-1:0]    in_sum,
  input  logic                       sym_mode,
  input  logic                       coef_neg,
  input  logic                       tbl_we,
  input  logic [ADDR_W-1:0]          tbl_addr,
  input  logic [DATA_W-1:0]          tbl_data,
  output logic                       out_valid,
  output logic signed [DATA_W:0]     out_value
);
  localparam int OUT_W = DATA_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SUM_W-1:0] SAT_LIM =
    {{(SUM_W-ADDR_W-FRAC_W-1){1'b0}}, 1'b1, {(ADDR_W+FRAC_W){1'b0}}};
  localparam logic signed [OUT_W-1:0] FULL = {1'b0, {DATA_W{1'b1}}};

  logic                neg0;
  logic [SUM_W-1:0]    mag0;
  logic [ADDR_W-1:0]   addr0;

  assign neg0  = in_sum[SUM_W-1];
  assign mag0  = neg0 ? SUM_W'(-in_sum) : in_sum;
  assign addr0 = (mag0 >= SAT_LIM) ? {ADDR_W{1'b1}} : mag0[FRAC_W +: ADDR_W];

  logic              v1, neg1, mode1, coef1;
  logic [ADDR_W-1:0] addr1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; neg1 <= 1'b0; mode1 <= 1'b0; coef1 <= 1'b0; addr1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        neg1 <= neg0; mode1 <= sym_mode; coef1 <= coef_neg; addr1 <= addr0;
      end
    end
  end

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (tbl_we) mem[tbl_addr] <= tbl_data;
  end

  logic signed [OUT_W-1:0] tv, folded, res;

  assign tv     = $signed({1'b0, mem[addr1]});
  assign folded = !neg1 ? tv : (mode1 ? FULL - tv : -tv);
  assign res    = coef1 ? -folded : folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= v1;
      out_value <= v1 ? res : '0;
    end
  end
endmodule

// File: rtl/act_lut_unit_chk.sv
module act_lut_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_sign,
  input logic                   sym_mode,
  input logic                   coef_neg,
  input logic                   out_valid,
  input logic signed [DATA_W:0] out_value
);
  localparam int LIM = (1 << DATA_W) - 1;
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !out_valid) |-> (out_value == '0)); // R7
  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid) |-> (int'(out_value) >= -LIM && int'(out_value) <= LIM)); // R6
  AST_OFFSET_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid && $past(sym_mode, 2) && !$past(coef_neg, 2)) |-> !out_value[DATA_W]); // R5
  AST_POS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && out_valid && !$past(in_sign, 2) && !$past(coef_neg, 2)) |-> !out_value[DATA_W]); // R4
endmodule

bind act_lut_unit act_lut_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sum[SUM_W-1]),
  .sym_mode(sym_mode), .coef_neg(coef_neg),
  .out_valid(out_valid), .out_value(out_value)
);

// File: tb/sim_act_lut_unit.sv
`timescale 1ns/1ps
module sim_act_lut_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [23:0] in_sum = '0;
  logic sym_mode = 1'b0, coef_neg = 1'b0;
  logic tbl_we = 1'b0;
  logic [7:0] tbl_addr = '0, tbl_data = '0;
  logic out_valid;
  logic signed [8:0] out_value;

  int checks = 0, failures = 0;
  string cur_req = "R8";
  int ref_tbl [256];

  always #5 clk = ~clk;

  act_lut_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sum(in_sum),
    .sym_mode(sym_mode), .coef_neg(coef_neg), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_value(out_value)
  );

  function automatic int ref_fn(int s, bit mode, bit coef);
    bit neg = (s < 0);
    int m = neg ? -s : s;
    int q = m / 256;
    int t, v;
    if (q > 255) q = 255;
    t = ref_tbl[q];
    if (!neg) v = t;
    else if (mode) v = 255 - t;
    else v = -t;
    return coef ? -v : v;
  endfunction

  bit p_v = 0, e_v = 0, p_mode = 0, p_coef = 0;
  int p_sum = 0, e_val = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_v = 0; e_v = 0; e_val = 0;
    end else begin
      e_v = p_v;
      e_val = p_v ? ref_fn(p_sum, p_mode, p_coef) : 0;
      p_v = in_valid; p_sum = int'(in_sum); p_mode = sym_mode; p_coef = coef_neg;
      if (tbl_we) ref_tbl[tbl_addr] = int'(tbl_data);
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== e_v || int'(out_value) != e_val) begin
      failures++;
      $display("FAIL %s: out_valid=%0b out_value=%0d expected valid=%0b value=%0d",
               cur_req, out_valid, out_value, e_v, e_val);
    end
  end

  task automatic step(bit v, int s, bit m, bit c, bit we, int a, int d);
    @(negedge clk);
    in_valid = v; in_sum = 24'(s); sym_mode = m; coef_neg = c;
    tbl_we = we; tbl_addr = 8'(a); tbl_data = 8'(d);
  endtask

  task automatic look(int s, bit m, bit c);
    step(1, s, m, c, 0, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_tbl[i] = 0;
    cur_req = "R8";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 1, i, (i * 37 + 11) & 255);
    idle(2);

    cur_req = "R9";
    look(0, 0, 0); look(0, 1, 0); idle(3);

    cur_req = "R3";
    look('h105, 0, 0); look('h1FF, 0, 0); look(-'h1FF, 0, 0);
    look('hFF, 0, 0); look(-'hFF, 1, 0); look('h4A80, 0, 0); idle(3);

    cur_req = "R4";
    for (int k = -20; k <= 20; k++) look(k * 1500 + 7, 0, 0);
    idle(3);

    cur_req = "R5";
    for (int k = -20; k <= 20; k++) look(k * 1500 - 3, 1, 0);
    idle(3);

    cur_req = "R6";
    for (int k = -10; k <= 10; k++) look(k * 3001, k[0], 1);
    idle(3);

    cur_req = "R2";
    look('h7FFFFF, 0, 0); look(-'h800000, 0, 0); look(-'h800000, 1, 0);
    look('h10000, 0, 0); look('hFFFF, 0, 0); look(-'h10000, 1, 1);
    look(-'hFFFF, 0, 0); idle(3);

    cur_req = "R7";
    look(300, 0, 0); idle(1); look(-900, 1, 0); idle(2);
    for (int k = 0; k < 20; k++) look(k * 977 - 9000, k[1], k[2]);
    idle(4);

    cur_req = "R1";
    step(1, 'h500, 0, 0, 1, 5, 200);
    idle(2);
    look('h600, 0, 0);
    step(0, 0, 0, 0, 1, 6, 17);
    idle(2);
    look('h600, 0, 0);
    step(1, -'h700, 1, 0, 1, 7, 99);
    idle(3);

    cur_req = "R8";
    look(1234, 0, 0); look(-4321, 1, 1);
    @(negedge clk);
    in_valid = 0;
    rst_n = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_value !== 9'sd0) begin
      failures++;
      $display("FAIL R8: out_valid=%0b out_value=%0d expected valid=0 value=0",
               out_valid, out_value);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule